// File: doc/BRIEF.md
# CPRI IQ Sample Format Converter

This block sits between the IQ field of a CPRI basic frame and a 32-bit internal sample bus. On the link side, each antenna-carrier sample is one field in which the I and Q bits alternate. On the internal side, the same sample appears as separate I and Q values, each aligned to a byte lane. One receive path and one transmit path work independently of each other. Each path has a valid/ready handshake at both of its ends.

The receive path separates each link field into I and Q. It sign-extends 7-bit samples to 8-bit lanes and 15-bit samples to 16-bit lanes. The narrow formats carry two samples per internal word; the wide formats carry one.

The transmit path takes byte-lane or half-word-lane values from the internal bus. It clamps each value that is too large for a 7-bit or 15-bit link sample to that width's limit rather than letting it wrap. It then interleaves the clamped bits into the link field. In the 8-bit and 16-bit formats every bit, including the bits that carry reserved information at the 2x rate, crosses the converter unchanged.

Top module: `cpri_iq_conv`

## Requirements
- R1: The format input `cfg_fmt` selects the sample width: 0 = 7-bit, 1 = 8-bit, 2 = 15-bit, 3 = 16-bit. In every format, bit k of I sits at link bit 2k and bit k of Q sits at link bit 2k+1, counting from link bit 0. On receive, link bits above the sample field are ignored.
- R2: In the 7-bit format, each received I and Q value is placed in an 8-bit lane, and bit 6 is copied into bit 7.
- R3: In the 15-bit format, each received I and Q value is placed in a 16-bit lane, and bit 14 is copied into bit 15.
- R4: In the 7-bit and 8-bit formats, two received samples fill one internal word. The earlier sample goes to bits [15:0] and the later one to bits [31:16]. Within each half, I is in the low byte and Q is in the high byte. The same layout is read on transmit, and the sample in bits [15:0] is sent first.
- R5: In the 15-bit and 16-bit formats, each internal word holds one sample, with I in bits [15:0] and Q in bits [31:16]. This holds in both directions.
- R6: In the 8-bit and 16-bit formats, every bit of every sample, including the most significant (reserved) bit, passes unchanged in both directions. No extension or saturation is applied.
- R7: In the 7-bit format, the transmit path clamps a signed 8-bit lane value above 63 to 63 and one below -64 to -64. Values inside that range are sent unchanged.
- R8: In the 15-bit format, the transmit path clamps a signed 16-bit lane value above 16383 to 16383 and one below -16384 to -16384. Values inside that range are sent unchanged.
- R9: Transmitted link words carry zeros in every bit above the 2N bits of an N-bit sample.
- R10: An output that is valid but not accepted keeps its data unchanged. Under any ready pattern, every sample is delivered exactly once and in order.
- R11: Directly after reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Sample format select; change only while both paths are idle |
| lnk_rx_valid | input | 1 | Received link field is present |
| lnk_rx_ready | output | 1 | Receive path accepts a link field |
| lnk_rx_data | input | 2*SMP_MAX | Received interleaved IQ field |
| smp_rx_valid | output | 1 | Receive-side internal word is present |
| smp_rx_ready | input | 1 | Consumer takes the internal word |
| smp_rx_data | output | 2*SMP_MAX | Byte-aligned I/Q word |
| smp_tx_valid | input | 1 | Internal word to transmit is present |
| smp_tx_ready | output | 1 | Transmit path accepts an internal word |
| smp_tx_data | input | 2*SMP_MAX | Byte-aligned I/Q word to transmit |
| lnk_tx_valid | output | 1 | Transmit link field is present |
| lnk_tx_ready | input | 1 | Link side takes the field |
| lnk_tx_data | output | 2*SMP_MAX | Interleaved, saturated IQ field |

## Verification
The bench sweeps every I/Q pair of the 7-bit receive format. This separates a wrong bit interleave from a wrong sign extension, because each link bit takes every value against every other. The 8-bit and 16-bit formats get patterns whose top bit is set, which tell true pass-through apart from accidental extension or clamping. Transmit lanes run through the full 8-bit range and through the points around each clamp limit, so an off-by-one threshold or a wrapped value shows up. Each format is run once with continuous ready and once with random backpressure. The backpressure run exposes lost, duplicated or reordered samples and any mix-up of the two halves of a narrow word.

// File: rtl/iqfc_pkg.sv
package iqfc_pkg;

  typedef enum logic [1:0] {
    FMT_S7  = 2'd0,
    FMT_S8  = 2'd1,
    FMT_S15 = 2'd2,
    FMT_S16 = 2'd3
  } iq_fmt_e;

  // number of sample bits carried per I or Q on the link
  function automatic int smp_keep(iq_fmt_e f, int smax);
    case (f)
      FMT_S7:  return smax / 2 - 1;
      FMT_S8:  return smax / 2;
      FMT_S15: return smax - 1;
      default: return smax;
    endcase
  endfunction

  function automatic logic is_narrow(iq_fmt_e f);
    return (f == FMT_S7) || (f == FMT_S8);
  endfunction

  // width of one internal lane for the format
  function automatic int lane_bits(iq_fmt_e f, int smax);
    return is_narrow(f) ? smax / 2 : smax;
  endfunction

endpackage

// File: rtl/iqfc_bit_split.sv
module iqfc_bit_split #(
  parameter int SMP_W = 16
) (
  input  logic [2*SMP_W-1:0] field,
  output logic [SMP_W-1:0]   i_bits,
  output logic [SMP_W-1:0]   q_bits
);
  for (genvar b = 0; b < SMP_W; b++) begin : g_bit
    assign i_bits[b] = field[2*b];
    assign q_bits[b] = field[2*b+1];
  end
endmodule

// File: rtl/iqfc_bit_merge.sv
module iqfc_bit_merge #(
  parameter int SMP_W = 16
) (
  input  logic [SMP_W-1:0]   i_bits,
  input  logic [SMP_W-1:0]   q_bits,
  output logic [2*SMP_W-1:0] field
);
  for (genvar b = 0; b < SMP_W; b++) begin : g_bit
    assign field[2*b]   = i_bits[b];
    assign field[2*b+1] = q_bits[b];
  end
endmodule

// File: rtl/iqfc_rx_path.sv
module iqfc_rx_path
  import iqfc_pkg::*;
#(
  parameter int SMP_MAX = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  iq_fmt_e                fmt,
  input  logic                   lv,
  output logic                   lr,
  input  logic [2*SMP_MAX-1:0]   ld,
  output logic                   ov,
  input  logic                   orr,
  output logic [2*SMP_MAX-1:0]   od
);
  localparam int HALF = SMP_MAX / 2;
  localparam int LW   = 2 * SMP_MAX;

  logic [SMP_MAX-1:0] i_raw, q_raw;
  logic [SMP_MAX-1:0] i_ext, q_ext;
  logic [SMP_MAX-1:0] pair_nar;
  logic [SMP_MAX-1:0] hold;
  logic               half_q;
  logic               narrow, stash, acc;
  int                 keep, lane;

  iqfc_bit_split #(.SMP_W(SMP_MAX)) u_split (
    .field (ld),
    .i_bits(i_raw),
    .q_bits(q_raw)
  );

  always_comb begin
    keep = smp_keep(fmt, SMP_MAX);
    lane = lane_bits(fmt, SMP_MAX);
    for (int b = 0; b < SMP_MAX; b++) begin
      i_ext[b] = (b < keep) ? i_raw[b] : ((b < lane) ? i_raw[keep-1] : 1'b0);
      q_ext[b] = (b < keep) ? q_raw[b] : ((b < lane) ? q_raw[keep-1] : 1'b0);
    end
  end

  assign pair_nar = {q_ext[HALF-1:0], i_ext[HALF-1:0]};
  assign narrow   = is_narrow(fmt);
  assign stash    = narrow && !half_q;
  assign lr       = stash || !ov || orr;
  assign acc      = lv && lr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ov     <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (ov && orr) ov <= 1'b0;
      if (acc) begin
        if (stash) begin
          hold   <= pair_nar;
          half_q <= 1'b1;
        end else begin
          od     <= narrow ? {pair_nar, hold} : {q_ext, i_ext};
          ov     <= 1'b1;
          half_q <= 1'b0;
        end
      end
    end
  end

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ov && !orr |=> ov && $stable(od));
  // R2
  rx_ext7_chk: assert property (@(posedge clk) disable iff (rst)
    ov && fmt == FMT_S7 |-> od[HALF-1] == od[HALF-2] && od[2*HALF-1] == od[2*HALF-2]
      && od[3*HALF-1] == od[3*HALF-2] && od[LW-1] == od[LW-2]);
  // R3
  rx_ext15_chk: assert property (@(posedge clk) disable iff (rst)
    ov && fmt == FMT_S15 |-> od[SMP_MAX-1] == od[SMP_MAX-2] && od[LW-1] == od[LW-2]);
  // R11
  rx_rst_chk: assert property (@(posedge clk) rst |=> !ov && lr);
endmodule

// File: rtl/iqfc_tx_path.sv
module iqfc_tx_path
  import iqfc_pkg::*;
#(
  parameter int SMP_MAX = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  iq_fmt_e                fmt,
  input  logic                   iv,
  output logic                   ir,
  input  logic [2*SMP_MAX-1:0]   id,
  output logic                   ov,
  input  logic                   orr,
  output logic [2*SMP_MAX-1:0]   od
);
  localparam int HALF = SMP_MAX / 2;
  localparam int LW   = 2 * SMP_MAX;

  logic               w_v, ph;
  logic [LW-1:0]      w_d;
  logic [SMP_MAX-1:0] pair, i_lane, q_lane, i_sat, q_sat;
  logic [LW-1:0]      field;
  logic               narrow, adv, last;
  int                 keep, lane;

  // clamp a signed lane value to a signed keep-bit result
  function automatic logic [SMP_MAX-1:0] clamp(input logic [SMP_MAX-1:0] v,
                                               input int ln, input int kp);
    logic sgn, fits;
    clamp = '0;
    sgn   = v[ln-1];
    fits  = 1'b1;
    for (int b = 0; b < SMP_MAX; b++)
      if (b >= kp - 1 && b < ln && v[b] != sgn) fits = 1'b0;
    for (int b = 0; b < SMP_MAX; b++)
      if (b < kp) clamp[b] = fits ? v[b] : ((b == kp - 1) ? sgn : ~sgn);
  endfunction

  assign narrow = is_narrow(fmt);
  assign pair   = ph ? w_d[LW-1:SMP_MAX] : w_d[SMP_MAX-1:0];

  always_comb begin
    keep = smp_keep(fmt, SMP_MAX);
    lane = lane_bits(fmt, SMP_MAX);
    if (narrow) begin
      i_lane = {{(SMP_MAX-HALF){1'b0}}, pair[HALF-1:0]};
      q_lane = {{(SMP_MAX-HALF){1'b0}}, pair[SMP_MAX-1:HALF]};
    end else begin
      i_lane = w_d[SMP_MAX-1:0];
      q_lane = w_d[LW-1:SMP_MAX];
    end
    i_sat = clamp(i_lane, lane, keep);
    q_sat = clamp(q_lane, lane, keep);
  end

  iqfc_bit_merge #(.SMP_W(SMP_MAX)) u_merge (
    .i_bits(i_sat),
    .q_bits(q_sat),
    .field (field)
  );

  assign adv  = w_v && (!ov || orr);
  assign last = !narrow || ph;
  assign ir   = !w_v || (adv && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_v <= 1'b0;
      ph  <= 1'b0;
      ov  <= 1'b0;
    end else begin
      if (ov && orr) ov <= 1'b0;
      if (adv) begin
        od <= field;
        ov <= 1'b1;
        if (last) begin
          w_v <= 1'b0;
          ph  <= 1'b0;
        end else begin
          ph <= 1'b1;
        end
      end
      if (iv && ir) begin
        w_v <= 1'b1;
        w_d <= id;
        ph  <= 1'b0;
      end
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ov && !orr |=> ov && $stable(od));
  // R10
  tx_word_keep_chk: assert property (@(posedge clk) disable iff (rst)
    w_v && !adv |=> w_v && $stable(w_d));
  // R9
  tx_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ov |-> (od >> (2 * keep)) == '0);
  // R11
  tx_rst_chk: assert property (@(posedge clk) rst |=> !ov && ir);
endmodule

// File: rtl/cpri_iq_conv.sv
module cpri_iq_conv
  import iqfc_pkg::*;
#(
  parameter int SMP_MAX = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           cfg_fmt,
  input  logic                 lnk_rx_valid,
  output logic                 lnk_rx_ready,
  input  logic [2*SMP_MAX-1:0] lnk_rx_data,
  output logic                 smp_rx_valid,
  input  logic                 smp_rx_ready,
  output logic [2*SMP_MAX-1:0] smp_rx_data,
  input  logic                 smp_tx_valid,
  output logic                 smp_tx_ready,
  input  logic [2*SMP_MAX-1:0] smp_tx_data,
  output logic                 lnk_tx_valid,
  input  logic                 lnk_tx_ready,
  output logic [2*SMP_MAX-1:0] lnk_tx_data
);
  iq_fmt_e fmt;
  assign fmt = iq_fmt_e'(cfg_fmt);

  iqfc_rx_path #(.SMP_MAX(SMP_MAX)) u_rx (
    .clk(clk), .rst(rst), .fmt(fmt),
    .lv(lnk_rx_valid), .lr(lnk_rx_ready), .ld(lnk_rx_data),
    .ov(smp_rx_valid), .orr(smp_rx_ready), .od(smp_rx_data)
  );

  iqfc_tx_path #(.SMP_MAX(SMP_MAX)) u_tx (
    .clk(clk), .rst(rst), .fmt(fmt),
    .iv(smp_tx_valid), .ir(smp_tx_ready), .id(smp_tx_data),
    .ov(lnk_tx_valid), .orr(lnk_tx_ready), .od(lnk_tx_data)
  );
endmodule

// File: tb/tb_cpri_iq_conv.sv
module tb_cpri_iq_conv;
  localparam int SMP = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_fmt = 2'd0;
  logic lnk_rx_valid = 1'b0, lnk_rx_ready;
  logic [2*SMP-1:0] lnk_rx_data = '0;
  logic smp_rx_valid, smp_rx_ready = 1'b1;
  logic [2*SMP-1:0] smp_rx_data;
  logic smp_tx_valid = 1'b0, smp_tx_ready;
  logic [2*SMP-1:0] smp_tx_data = '0;
  logic lnk_tx_valid, lnk_tx_ready = 1'b1;
  logic [2*SMP-1:0] lnk_tx_data;

  int n_chk = 0, n_fail = 0;
  bit bp_on = 1'b0;
  logic [31:0] rxq[$];
  logic [31:0] txq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpri_iq_conv #(.SMP_MAX(SMP)) dut (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int keep_of(int f);
    case (f) 0: return 7; 1: return 8; 2: return 15; default: return 16; endcase
  endfunction
  function automatic int lane_of(int f);
    return (f < 2) ? 8 : 16;
  endfunction
  function automatic logic [31:0] weave(int n, int iv, int qv);
    logic [31:0] r = '0;
    for (int b = 0; b < n; b++) begin
      r[2*b]   = iv[b];
      r[2*b+1] = qv[b];
    end
    return r;
  endfunction
  // receive: raw n-bit value to l-bit lane by arithmetic sign extension
  function automatic int sext(int v, int n, int l);
    if (n == l) return v;
    return (v >= (1 << (n-1))) ? v - (1 << n) + (1 << l) : v;
  endfunction
  // transmit: l-bit lane value to n-bit clamped code
  function automatic int sat(int v, int l, int n);
    int sv, hi, lo;
    sv = (v >= (1 << (l-1))) ? v - (1 << l) : v;
    hi = (1 << (n-1)) - 1;
    lo = -(1 << (n-1));
    if (sv > hi) sv = hi;
    if (sv < lo) sv = lo;
    return sv & ((1 << n) - 1);
  endfunction
  function automatic int rx_gen(int k, int n);
    case (k)
      0: return 0;
      1: return (1 << (n-1)) - 1;
      2: return 1 << (n-1);
      3: return (1 << n) - 1;
      default: return (k * 40503 + 17) & ((1 << n) - 1);
    endcase
  endfunction
  function automatic int tx_gen(int k, int l, int n);
    case (k)
      0: return 0;
      1: return (1 << (n-1)) - 1;
      2: return 1 << (n-1);
      3: return (1 << l) - (1 << (n-1));
      4: return (1 << l) - (1 << (n-1)) - 1;
      5: return (1 << (l-1)) - 1;
      6: return 1 << (l-1);
      7: return (1 << l) - 1;
      default: return (k * 40503 + 5) & ((1 << l) - 1);
    endcase
  endfunction
  function automatic string rx_tag(int f);
    case (f) 0: return "R1 R2 R4"; 1: return "R1 R4 R6"; 2: return "R1 R3 R5"; default: return "R1 R5 R6"; endcase
  endfunction
  function automatic string tx_tag(int f);
    case (f) 0: return "R7 R9 R4"; 1: return "R6 R9 R4"; 2: return "R8 R9 R5"; default: return "R6 R9 R5"; endcase
  endfunction

  task automatic rx_run(int f, int total);
    int n, l, iv, qv, li, lq;
    logic [15:0] pend;
    n = keep_of(f);
    l = lane_of(f);
    pend = '0;
    for (int k = 0; k < total; k++) begin
      if (f == 0) begin
        iv = k & 127;
        qv = k >> 7;
      end else begin
        iv = rx_gen(k, n);
        qv = rx_gen((k + 3) % total, n);
      end
      li = sext(iv, n, l);
      lq = sext(qv, n, l);
      @(negedge clk);
      lnk_rx_valid = 1'b1;
      // R1: bits above the field carry junk that must be ignored
      lnk_rx_data = weave(n, iv, qv) | (32'hA5A5_5A5A << (2*n));
      #1;
      while (!lnk_rx_ready) begin
        @(negedge clk);
        #1;
      end
      if (l == 8) begin
        if (k % 2 == 0) pend = {lq[7:0], li[7:0]};
        else rxq.push_back({lq[7:0], li[7:0], pend});
      end else begin
        rxq.push_back({lq[15:0], li[15:0]});
      end
    end
    @(negedge clk);
    lnk_rx_valid = 1'b0;
  endtask

  task automatic tx_run(int f, int words);
    int n, l, a, b, c, d;
    n = keep_of(f);
    l = lane_of(f);
    for (int j = 0; j < words; j++) begin
      if (l == 8) begin
        a = (2*j) & 255;
        b = tx_gen(2*j, 8, n);
        c = (2*j + 1) & 255;
        d = tx_gen(2*j + 1, 8, n);
        @(negedge clk);
        smp_tx_valid = 1'b1;
        smp_tx_data = {d[7:0], c[7:0], b[7:0], a[7:0]};
      end else begin
        a = tx_gen(j, 16, n);
        b = tx_gen((j + 5) % words, 16, n);
        @(negedge clk);
        smp_tx_valid = 1'b1;
        smp_tx_data = {b[15:0], a[15:0]};
      end
      #1;
      while (!smp_tx_ready) begin
        @(negedge clk);
        #1;
      end
      txq.push_back(weave(n, sat(a, l, n), sat(b, l, n)));
      if (l == 8) txq.push_back(weave(n, sat(c, l, n), sat(d, l, n)));
    end
    @(negedge clk);
    smp_tx_valid = 1'b0;
  endtask

  // receive-side sink
  initial begin
    forever begin
      @(negedge clk);
      smp_rx_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (smp_rx_valid === 1'b1 && smp_rx_ready) begin
        if (rxq.size() == 0) chk(1'b0, "R10 extra rx word", smp_rx_data, '0);
        else begin
          logic [31:0] e;
          e = rxq.pop_front();
          chk(smp_rx_data === e, rx_tag(int'(cfg_fmt)), smp_rx_data, e);
        end
      end
    end
  end

  // transmit-side sink
  initial begin
    forever begin
      @(negedge clk);
      lnk_tx_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (lnk_tx_valid === 1'b1 && lnk_tx_ready) begin
        if (txq.size() == 0) chk(1'b0, "R10 extra tx field", lnk_tx_data, '0);
        else begin
          logic [31:0] e;
          e = txq.pop_front();
          chk(lnk_tx_data === e, tx_tag(int'(cfg_fmt)), lnk_tx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R11
    chk(smp_rx_valid == 1'b0, "R11 rx valid", 32'(smp_rx_valid), 0);
    chk(lnk_tx_valid == 1'b0, "R11 tx valid", 32'(lnk_tx_valid), 0);
    chk(lnk_rx_ready == 1'b1, "R11 rx ready", 32'(lnk_rx_ready), 1);
    chk(smp_tx_ready == 1'b1, "R11 tx ready", 32'(smp_tx_ready), 1);
    for (int pass = 0; pass < 2; pass++) begin
      for (int f = 0; f < 4; f++) begin
        cfg_fmt = 2'(f);
        bp_on = (pass == 1); // R10: random backpressure on the second pass
        fork
          rx_run(f, (f == 0) ? ((pass == 0) ? 16384 : 2048) : 2048);
          tx_run(f, (f < 2) ? 1024 : 2048);
        join
        for (int w = 0; w < 200 && (rxq.size() != 0 || txq.size() != 0); w++)
          @(negedge clk);
        repeat (4) @(negedge clk);
        // R10: every accepted sample delivered
        chk(rxq.size() == 0, "R10 rx words lost", 32'(rxq.size()), 0);
        chk(txq.size() == 0, "R10 tx fields lost", 32'(txq.size()), 0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule